// File: doc/BRIEF.md
# ECC Syndrome Classifier and Byte Fixer

This block takes two 3-byte error-correcting codes for one 256-byte data block. One is the code stored with the data. The other was just computed over the data as read back. The block XORs them into a 24-bit syndrome and sorts the result into one of four classes:

- the data is clean;
- one data bit is wrong, and its byte address and bit position are known;
- exactly one bit of the stored code is wrong, so the stored code should be replaced with the computed one;
- the damage cannot be corrected.

The verdict is registered and appears one cycle after the input strobe, together with a one-cycle result pulse. It stays held until the next strobe.

While a verdict is held, the caller can stream data bytes through a patch port, each byte with its address. The byte whose address matches a correctable error leaves the port with the faulty bit inverted. Every other byte passes through unchanged, one cycle later. Generating the codes and buffering the data are left to neighbouring logic.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: While reset is high, and on the first cycle after it, res_valid, res_status, err_addr, err_bit, replace_code and fixed_byte are all zero.
- R2: res_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise.
- R3: The syndrome is calc_code XOR read_code, with byte S1 in bits 23:16, S2 in bits 15:8 and S3 in bits 7:0. An all-zero syndrome gives res_status 0.
- R4: If the syndrome is nonzero and the following pairs all hold opposite values, res_status is 1:
  - bits (7,6), (5,4), (3,2) and (1,0) of S1;
  - the same four pairs of S2;
  - bits (7,6), (5,4) and (3,2) of S3.

  In that case err_addr is {S1[7],S1[5],S1[3],S1[1],S2[7],S2[5],S2[3],S2[1]} and err_bit is {S3[7],S3[5],S3[3]}.
- R5: Otherwise, if exactly one of the 24 syndrome bits is set, res_status is 2 and replace_code is 1.
- R6: Any other syndrome gives res_status 3.
- R7: err_addr and err_bit are zero whenever res_status is not 1. replace_code is 1 exactly when res_status is 2.
- R8: One cycle after fix_addr and fix_byte are presented, fixed_byte holds one of two values. If the held res_status is 1 and fix_addr equals err_addr, it is fix_byte XOR (1 << err_bit). In every other case it is fix_byte unchanged.
- R9: res_status, err_addr, err_bit and replace_code keep their values in every cycle that follows a cycle with in_valid low.
- R10: Bits 1 and 0 of S3 have no effect on whether a syndrome is classified as status 1, nor on the address or bit reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: the two codes are valid this cycle |
| calc_code | input | 24 | Code computed over the data as read |
| read_code | input | 24 | Code stored with the data |
| fix_addr | input | 8 | Byte address of the byte on fix_byte |
| fix_byte | input | 8 | Data byte to pass through the patch port |
| res_valid | output | 1 | One-cycle pulse: a new verdict is on the outputs |
| res_status | output | 2 | 0 clean, 1 data bit fixed, 2 code bit wrong, 3 uncorrectable |
| err_addr | output | 8 | Byte address of the faulty data bit |
| err_bit | output | 3 | Bit position of the faulty data bit |
| replace_code | output | 1 | The stored code should be overwritten with the computed one |
| fixed_byte | output | 8 | fix_byte, with the faulty bit inverted when it is addressed |

## Verification
The bench builds the block with its default byte width of 8. That gives a 24-bit code, 256 byte addresses and 8 bit positions, all small enough for random stimulus to reach every address and bit index.

Random syndromes are weighted across the four classes. Each data-error syndrome is built from a random address and bit, so decoding is exercised over the whole address space. Patch requests alternate between the faulty address and a neighbouring one.

Directed cases cover:
- the all-zero, all-ones and lowest and highest address patterns;
- a lone set bit in the two S3 bits that classification ignores;
- the hold behaviour across idle cycles.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

  // Verdict encoding driven onto res_status
  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_BAD   = 2'd3
  } ecc_status_e;

  // Number of bytes in one code word
  localparam int CODE_BYTES = 3;

endpackage

// File: rtl/ecc_pair_check.sv
// Tests that the upper NUSE bit pairs of one syndrome byte are complementary
// and extracts the odd (upper) bit of every pair.
module ecc_pair_check #(
  parameter  int BYTE_W = 8,
  parameter  int NUSE   = 4,
  localparam int PAIRS  = BYTE_W / 2
) (
  input  logic [BYTE_W-1:0] syn_byte,
  output logic              pairs_ok,
  output logic [PAIRS-1:0]  odd_bits
);

  logic [PAIRS-1:0] cmpl;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    if (k >= PAIRS - NUSE) begin : g_used
      assign cmpl[k]     = syn_byte[2*k+1] ^ syn_byte[2*k];
      assign odd_bits[k] = syn_byte[2*k+1];
    end else begin : g_skip
      logic unused_pair;
      assign unused_pair = ^syn_byte[2*k+1 -: 2];
      assign cmpl[k]     = 1'b1;
      assign odd_bits[k] = 1'b0;
    end
  end

  assign pairs_ok = &cmpl;

endmodule

// File: rtl/ecc_syn_classify.sv
// Combinational syndrome formation and classification.
module ecc_syn_classify
  import ecc_syn_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CODE_W = CODE_BYTES * BYTE_W,
  localparam int PAIRS  = BYTE_W / 2,
  localparam int ADDR_W = 2 * PAIRS,
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int CNT_W  = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] read_code,
  output ecc_status_e       verdict,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [BIT_W-1:0]  loc_bit
);

  logic [CODE_W-1:0]  syn_all;
  logic [BYTE_W-1:0]  syn_byte [CODE_BYTES];
  logic [PAIRS-1:0]   odd      [CODE_BYTES];
  logic [CODE_BYTES-1:0] byte_ok;
  logic [CNT_W-1:0]   ones;

  assign syn_all = calc_code ^ read_code;

  // One pair checker per code byte; the last byte carries only BIT_W pairs
  for (genvar g = 0; g < CODE_BYTES; g++) begin : g_byte
    localparam int NU = (g == CODE_BYTES - 1) ? BIT_W : PAIRS;
    assign syn_byte[g] = syn_all[CODE_W-1-g*BYTE_W -: BYTE_W];
    ecc_pair_check #(
      .BYTE_W (BYTE_W),
      .NUSE   (NU)
    ) i_pair (
      .syn_byte (syn_byte[g]),
      .pairs_ok (byte_ok[g]),
      .odd_bits (odd[g])
    );
  end

  // Population count of the full syndrome
  always_comb begin
    ones = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + CNT_W'(syn_all[i]);
    end
  end

  always_comb begin
    verdict = ST_BAD;
    if (syn_all == '0) begin
      verdict = ST_CLEAN;
    end else if (&byte_ok) begin
      verdict = ST_FIXED;
    end else if (ones == CNT_W'(1)) begin
      verdict = ST_CODE;
    end
  end

  assign loc_addr = {odd[0], odd[1]};
  assign loc_bit  = odd[CODE_BYTES-1][PAIRS-1 -: BIT_W];

  logic unused_odd;
  assign unused_odd = ^odd[CODE_BYTES-1];

endmodule

// File: rtl/ecc_byte_patch.sv
// Registered pass-through that inverts one bit of the addressed byte.
module ecc_byte_patch #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fix_en,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [BIT_W-1:0]  err_bit,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [BYTE_W-1:0] fix_byte,
  output logic [BYTE_W-1:0] fixed_byte
);

  logic [BYTE_W-1:0] flip_mask;
  logic              hit;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign flip_mask[i] = (err_bit == BIT_W'(i));
  end

  assign hit = fix_en && (fix_addr == err_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      fixed_byte <= '0;
    end else begin
      fixed_byte <= fix_byte ^ (hit ? flip_mask : '0);
    end
  end

endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
  import ecc_syn_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CODE_W = CODE_BYTES * BYTE_W,
  localparam int ADDR_W = BYTE_W,
  localparam int BIT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] read_code,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [BYTE_W-1:0] fix_byte,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [ADDR_W-1:0] err_addr,
  output logic [BIT_W-1:0]  err_bit,
  output logic              replace_code,
  output logic [BYTE_W-1:0] fixed_byte
);

  ecc_status_e       verdict;
  logic [ADDR_W-1:0] loc_addr;
  logic [BIT_W-1:0]  loc_bit;
  ecc_status_e       stat_q;

  ecc_syn_classify #(
    .BYTE_W (BYTE_W)
  ) i_classify (
    .calc_code (calc_code),
    .read_code (read_code),
    .verdict   (verdict),
    .loc_addr  (loc_addr),
    .loc_bit   (loc_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      stat_q       <= ST_CLEAN;
      err_addr     <= '0;
      err_bit      <= '0;
      replace_code <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        stat_q       <= verdict;
        err_addr     <= (verdict == ST_FIXED) ? loc_addr : '0;
        err_bit      <= (verdict == ST_FIXED) ? loc_bit  : '0;
        replace_code <= (verdict == ST_CODE);
      end
    end
  end

  assign res_status = stat_q;

  ecc_byte_patch #(
    .BYTE_W (BYTE_W),
    .ADDR_W (ADDR_W),
    .BIT_W  (BIT_W)
  ) i_patch (
    .clk        (clk),
    .rst        (rst),
    .fix_en     (stat_q == ST_FIXED),
    .err_addr   (err_addr),
    .err_bit    (err_bit),
    .fix_addr   (fix_addr),
    .fix_byte   (fix_byte),
    .fixed_byte (fixed_byte)
  );

endmodule

// File: rtl/ecc_syndrome_fixer_chk.sv
module ecc_syndrome_fixer_chk #(
  parameter  int BYTE_W = 8,
  localparam int CODE_W = 3 * BYTE_W,
  localparam int ADDR_W = BYTE_W,
  localparam int BIT_W  = $clog2(BYTE_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CODE_W-1:0] calc_code,
  input logic [CODE_W-1:0] read_code,
  input logic [ADDR_W-1:0] fix_addr,
  input logic [BYTE_W-1:0] fix_byte,
  input logic              res_valid,
  input logic [1:0]        res_status,
  input logic [ADDR_W-1:0] err_addr,
  input logic [BIT_W-1:0]  err_bit,
  input logic              replace_code,
  input logic [BYTE_W-1:0] fixed_byte
);

  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  p_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && calc_code == read_code) |=> res_status == 2'd0);

  p_code_err_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(calc_code ^ read_code) == 1)
      |=> (res_status == 2'd2 && replace_code));

  p_loc_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (res_status != 2'd1) |-> (err_addr == '0 && err_bit == '0));

  p_replace_r7: assert property (@(posedge clk) disable iff (rst)
    replace_code == (res_status == 2'd2));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_status) && $stable(err_addr)
                   && $stable(err_bit) && $stable(replace_code)));

  p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (res_status != 2'd1) |=> fixed_byte == $past(fix_byte));

  p_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (fix_addr != err_addr) |=> fixed_byte == $past(fix_byte));

endmodule

bind ecc_syndrome_fixer ecc_syndrome_fixer_chk #(.BYTE_W(BYTE_W)) i_chk (.*);

// File: tb/test_ecc_syndrome_fixer.sv
`timescale 1ns/1ps
module test_ecc_syndrome_fixer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] calc_code = '0;
  logic [23:0] read_code = '0;
  logic [7:0]  fix_addr = '0;
  logic [7:0]  fix_byte = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [7:0]  err_addr;
  logic [2:0]  err_bit;
  logic        replace_code;
  logic [7:0]  fixed_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ecc_syndrome_fixer i_ecc_syndrome_fixer (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .calc_code(calc_code), .read_code(read_code),
    .fix_addr(fix_addr), .fix_byte(fix_byte),
    .res_valid(res_valid), .res_status(res_status),
    .err_addr(err_addr), .err_bit(err_bit),
    .replace_code(replace_code), .fixed_byte(fixed_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Reference classification written from the requirements
  function automatic void ref_model(input logic [23:0] syn,
                                    output int st, output int ad, output int bt);
    logic [7:0] s1, s2, s3;
    bit ok;
    int pc;
    s1 = syn[23:16]; s2 = syn[15:8]; s3 = syn[7:0];
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (s1[2*k] == s1[2*k+1]) ok = 1'b0;
      if (s2[2*k] == s2[2*k+1]) ok = 1'b0;
      if (k > 0 && s3[2*k] == s3[2*k+1]) ok = 1'b0;
    end
    pc = 0;
    for (int i = 0; i < 24; i++) pc += int'(syn[i]);
    ad = 0; bt = 0;
    if (syn == 24'h0) st = 0;
    else if (ok) begin
      st = 1;
      ad = int'({s1[7], s1[5], s1[3], s1[1], s2[7], s2[5], s2[3], s2[1]});
      bt = int'({s3[7], s3[5], s3[3]});
    end else if (pc == 1) st = 2;
    else st = 3;
  endfunction

  function automatic logic [7:0] spread(input logic [3:0] v);
    logic [7:0] r;
    for (int k = 0; k < 4; k++) begin
      r[2*k+1] = v[k];
      r[2*k]   = ~v[k];
    end
    return r;
  endfunction

  function automatic logic [23:0] data_syn(input logic [7:0] a, input logic [2:0] b,
                                           input logic [1:0] lo);
    logic [7:0] s3;
    s3 = spread({b, 1'b0});
    s3[1:0] = lo;
    return {spread(a[7:4]), spread(a[3:0]), s3};
  endfunction

  task automatic run_vec(input logic [23:0] c, input logic [23:0] syn, input bit hit);
    int es, ea, eb;
    string tg;
    logic [7:0] fa, fb, ef;
    ref_model(syn, es, ea, eb);
    tg = (es == 0) ? "R3" : (es == 1) ? "R4" : (es == 2) ? "R5" : "R6";
    @(negedge clk);
    calc_code = c; read_code = c ^ syn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid pulse", int'(res_valid), 1);
    chk({tg, " status"}, int'(res_status), es);
    chk({tg, " R7 err_addr"}, int'(err_addr), ea);
    chk({tg, " R7 err_bit"}, int'(err_bit), eb);
    chk("R5 R7 replace_code", int'(replace_code), int'(es == 2));
    fa = hit ? 8'(ea) : 8'(ea + 1);
    fb = 8'($urandom);
    fix_addr = fa; fix_byte = fb;
    @(negedge clk);
    chk("R2 pulse ends", int'(res_valid), 0);
    ef = fb;
    if (es == 1 && int'(fa) == ea) ef = fb ^ (8'd1 << eb);
    chk("R8 fixed_byte", int'(fixed_byte), int'(ef));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk("R1 reset res_valid", int'(res_valid), 0);
    chk("R1 reset status", int'(res_status), 0);
    chk("R1 reset fixed_byte", int'(fixed_byte), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset err_addr", int'(err_addr), 0);
    chk("R1 post-reset replace", int'(replace_code), 0);

    // Directed corners
    run_vec(24'h123456, 24'h000000, 1'b1);              // R3 clean
    run_vec(24'hA5A5A5, 24'hFFFFFF, 1'b1);              // R6 all ones
    run_vec(24'h0F0F0F, 24'h555554, 1'b1);              // R4 addr 0 bit 0
    run_vec(24'h0F0F0F, 24'hAAAAA8, 1'b1);              // R4 addr FF bit 7
    run_vec(24'h0F0F0F, 24'hAAAAA8, 1'b0);              // R8 address miss
    run_vec(24'h3C3C3C, 24'h000001, 1'b1);              // R5 lone bit in ignored pair
    run_vec(24'h3C3C3C, 24'h800000, 1'b1);              // R5 lone bit at top
    run_vec(24'h3C3C3C, 24'h000300, 1'b1);              // R6 two bits
    for (int lo = 0; lo < 4; lo++) begin                 // R10 low S3 bits ignored
      run_vec(24'h777777, data_syn(8'h9C, 3'd5, 2'(lo)), 1'b1);
    end

    // R9: hold across idle cycles
    run_vec(24'h111111, data_syn(8'h42, 3'd3, 2'd0), 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 hold status", int'(res_status), 1);
    chk("R9 hold err_addr", int'(err_addr), 8'h42);
    chk("R9 hold err_bit", int'(err_bit), 3);

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [23:0] c, s;
      c = 24'($urandom);
      sel = $urandom_range(0, 3);
      case (sel)
        0: s = 24'h0;
        1: s = data_syn(8'($urandom), 3'($urandom), 2'($urandom));
        2: s = 24'h1 << $urandom_range(0, 23);
        default: s = 24'($urandom);
      endcase
      run_vec(c, s, 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule